// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one IEEE-754 scalar from the low end of a 128-bit source register value and rounds it to an integral value in the same format. The format is half, single or double precision, chosen at run time by a 2-bit type code. The rounding direction comes from a 2-bit mode input that follows the live rounding-mode setting of the surrounding floating-point unit. Only the low element of the 128-bit result carries the rounded value. The bits above it either come from the old destination register value (merge enabled) or are cleared (merge disabled).

Special values keep their class and sign. A signaling NaN comes out quiet and raises the invalid-operation flag. An illegal type code raises the undefined-encoding flag. The block never reports an inexact result, even when rounding changes the value. Outputs are registered, so every result appears one clock after its inputs are sampled.

The block is a single-cycle datapath with no state machine. For each format, a rounding core classifies the operand and computes one of three things: the pass-through value, the signed zero or one for small magnitudes, or the truncated magnitude plus an optional one-unit increment at the integer boundary. A lane stage then selects the active core and applies merge or zeroing to the upper bits.

Top module: `frint_unit`

## Requirements
- R1: Type code 2'b00 selects single precision (bits 31:0), 2'b01 selects double precision (bits 63:0) and 2'b11 selects half precision (bits 15:0). The element width is 8 << (code XOR 2'b10).
- R2: Type code 2'b10 raises undef_o, drives result_o to all zeros and keeps invalid_o low. When the parameter HALF_EN is 0, type code 2'b11 behaves the same way.
- R3: A zero or infinite operand is returned unchanged, sign included.
- R4: A quiet NaN (exponent all ones, top fraction bit 1) is returned unchanged and invalid_o stays low.
- R5: A signaling NaN (exponent all ones, top fraction bit 0, fraction nonzero) is returned with the top fraction bit set, sign and payload kept, and invalid_o high.
- R6: rmode_i 2'b00 rounds to nearest, and exact ties go to the even integer (0.5→0, 1.5→2, 2.5→2, -0.5→-0).
- R7: rmode_i 2'b01 rounds toward +infinity, 2'b10 toward -infinity and 2'b11 toward zero.
- R8: A nonzero operand with magnitude below 1.0, subnormals included, becomes a zero or a one carrying the operand's sign, as the mode dictates (for example -0.3 rounded up gives -0).
- R9: An operand whose unbiased exponent is at least the fraction width is returned unchanged.
- R10: invalid_o stays low for every operand that is not a signaling NaN, including operands whose rounded result differs from the input.
- R11: With merge_i high, the result bits above the element equal the same bits of dst_old_i.
- R12: With merge_i low, the result bits above the element are zero.
- R13: While rst_n is low, all outputs are zero. Otherwise the outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 128 | Source register value; the operand is in the low element |
| dst_old_i | input | 128 | Previous destination register value, used for merging |
| ftype_i | input | 2 | Format type code |
| rmode_i | input | 2 | Rounding mode (00 nearest-even, 01 up, 10 down, 11 toward zero) |
| merge_i | input | 1 | 1 keeps the upper destination bits, 0 clears them |
| result_o | output | 128 | Registered 128-bit result |
| undef_o | output | 1 | Registered undefined-encoding flag |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The embedded assertions check the following on every cycle:
- the response to the illegal type code;
- that the upper lane is kept when merging and cleared when not;
- that the sign survives single-precision rounding;
- that any raised invalid flag comes with a quiet-NaN result.

Only the directed scenarios can show that the rounded values themselves are correct. This covers ties to even, the four directions across all three formats, the small-magnitude zero-or-one outcomes, the pass-through of large values and the exact NaN payloads. The bench computes those expected values from an independent floor/ceiling model.

// File: rtl/frint_pkg.sv
package frint_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    typedef enum logic [1:0] {
        FMT_SINGLE,
        FMT_DOUBLE,
        FMT_HALF,
        FMT_BAD
    } fmt_t;

    localparam int REG_W = 128;

    function automatic fmt_t decode_fmt(input logic [1:0] code, input bit half_ok);
        fmt_t f;
        unique case (code)
            2'b00:   f = FMT_SINGLE;
            2'b01:   f = FMT_DOUBLE;
            2'b11:   f = half_ok ? FMT_HALF : FMT_BAD;
            default: f = FMT_BAD;
        endcase
        return f;
    endfunction

    // Decide whether the truncated magnitude gains one unit.
    function automatic logic round_away(input rmode_t m, input logic sgn,
                                        input logic above_half, input logic at_half,
                                        input logic nonzero, input logic int_odd);
        logic r;
        unique case (m)
            RM_NEAR: r = above_half | (at_half & int_odd);
            RM_UP:   r = nonzero & ~sgn;
            RM_DOWN: r = nonzero & sgn;
            RM_ZERO: r = 1'b0;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/frint_core.sv
module frint_core
    import frint_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    input  rmode_t                mode_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  snan_o
);
    localparam int MW   = EXP_W + FRAC_W;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [MW-1:0] ONE_MAG = MW'(BIAS) << FRAC_W;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic [MW-1:0]     mag;
    logic [MW-1:0]     low_mask, half, rem, trunc, unit;
    logic              int_odd, up;
    int                unb, k;

    assign sgn = op_i[MW];
    assign ex  = op_i[MW-1:FRAC_W];
    assign fr  = op_i[FRAC_W-1:0];
    assign mag = op_i[MW-1:0];

    always_comb begin
        res_o    = op_i;
        snan_o   = 1'b0;
        unb      = int'({1'b0, ex}) - BIAS;
        k        = 0;
        low_mask = '0;
        half     = '0;
        rem      = '0;
        trunc    = mag;
        unit     = '0;
        int_odd  = 1'b0;
        up       = 1'b0;
        if (ex == '1) begin
            // infinity and quiet NaN pass; signaling NaN is quietened
            if ((fr != '0) && !fr[FRAC_W-1]) begin
                res_o[FRAC_W-1] = 1'b1;
                snan_o          = 1'b1;
            end
        end else if (mag == '0) begin
            res_o = op_i;
        end else if (unb >= FRAC_W) begin
            res_o = op_i;
        end else if (unb < 0) begin
            up    = round_away(mode_i, sgn, (unb == -1) && (fr != '0),
                               (unb == -1) && (fr == '0), 1'b1, 1'b0);
            res_o = {sgn, up ? ONE_MAG : MW'(0)};
        end else begin
            k        = FRAC_W - unb;
            unit     = MW'(1) << k;
            low_mask = unit - MW'(1);
            half     = MW'(1) << (k - 1);
            rem      = mag & low_mask;
            trunc    = mag & ~low_mask;
            int_odd  = (k == FRAC_W) ? 1'b1 : |(mag & unit);
            up       = round_away(mode_i, sgn, rem > half, rem == half,
                                  rem != '0, int_odd);
            res_o    = {sgn, up ? trunc + unit : trunc};
        end
    end

endmodule

// File: rtl/frint_lane.sv
module frint_lane
    import frint_pkg::*;
(
    input  fmt_t               fmt_i,
    input  logic [15:0]        h_i,
    input  logic [31:0]        s_i,
    input  logic [63:0]        d_i,
    input  logic [REG_W-1:0]   dst_i,
    input  logic               merge_i,
    output logic [REG_W-1:0]   res_o
);
    always_comb begin
        unique case (fmt_i)
            FMT_HALF:   res_o = merge_i ? {dst_i[REG_W-1:16], h_i} : {{(REG_W-16){1'b0}}, h_i};
            FMT_SINGLE: res_o = merge_i ? {dst_i[REG_W-1:32], s_i} : {{(REG_W-32){1'b0}}, s_i};
            FMT_DOUBLE: res_o = merge_i ? {dst_i[REG_W-1:64], d_i} : {{(REG_W-64){1'b0}}, d_i};
            FMT_BAD:    res_o = '0;
            default:    res_o = '0;
        endcase
    end
endmodule

// File: rtl/frint_unit.sv
module frint_unit
    import frint_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [127:0] src_i,
    input  logic [127:0] dst_old_i,
    input  logic [1:0]   ftype_i,
    input  logic [1:0]   rmode_i,
    input  logic         merge_i,
    output logic [127:0] result_o,
    output logic         undef_o,
    output logic         invalid_o
);
    fmt_t         fmt;
    rmode_t       mode;
    logic [15:0]  h_res;
    logic [31:0]  s_res;
    logic [63:0]  d_res;
    logic         h_snan, s_snan, d_snan;
    logic         inv_d;
    logic [127:0] lane_res;
    logic         past_ok;
    logic         unused_src_hi;

    assign fmt           = decode_fmt(ftype_i, HALF_EN);
    assign mode          = rmode_t'(rmode_i);
    assign unused_src_hi = ^src_i[127:64];

    frint_core #(.EXP_W(8),  .FRAC_W(23)) u_single (.op_i(src_i[31:0]), .mode_i(mode), .res_o(s_res), .snan_o(s_snan));
    frint_core #(.EXP_W(11), .FRAC_W(52)) u_double (.op_i(src_i[63:0]), .mode_i(mode), .res_o(d_res), .snan_o(d_snan));

    generate
        if (HALF_EN) begin : g_half
            frint_core #(.EXP_W(5), .FRAC_W(10)) u_half (.op_i(src_i[15:0]), .mode_i(mode), .res_o(h_res), .snan_o(h_snan));
        end else begin : g_no_half
            assign h_res  = '0;
            assign h_snan = 1'b0;
        end
    endgenerate

    frint_lane u_lane (
        .fmt_i(fmt), .h_i(h_res), .s_i(s_res), .d_i(d_res),
        .dst_i(dst_old_i), .merge_i(merge_i), .res_o(lane_res)
    );

    always_comb begin
        unique case (fmt)
            FMT_HALF:   inv_d = h_snan;
            FMT_SINGLE: inv_d = s_snan;
            FMT_DOUBLE: inv_d = d_snan;
            default:    inv_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            undef_o   <= 1'b0;
            invalid_o <= 1'b0;
            past_ok   <= 1'b0;
        end else begin
            result_o  <= lane_res;
            undef_o   <= (fmt == FMT_BAD);
            invalid_o <= inv_d;
            past_ok   <= 1'b1;
        end
    end

    a_r2_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ftype_i) == 2'b10) |-> (undef_o && !invalid_o && result_o == '0));

    a_r11_merge_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(merge_i) && $past(ftype_i) == 2'b01) |-> (result_o[127:64] == $past(dst_old_i[127:64])));

    a_r12_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(merge_i) && $past(ftype_i) == 2'b00) |-> (result_o[127:32] == '0));

    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ftype_i) == 2'b00) |-> (result_o[31] == $past(src_i[31])));

    a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && invalid_o && $past(ftype_i) == 2'b00) |-> (result_o[30:22] == 9'h1FF));

endmodule

// File: tb/frint_unit_test.sv
`timescale 1ns/1ps
module frint_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src = '0, dst = '0;
    logic [1:0]   ftype = 2'b00, rmode = 2'b00;
    logic         merge = 1'b0;
    logic [127:0] result;
    logic         undef, invalid;
    int           checks = 0, fails = 0;

    always #4 clk = ~clk;

    frint_unit uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .dst_old_i(dst), .ftype_i(ftype),
        .rmode_i(rmode), .merge_i(merge), .result_o(result), .undef_o(undef), .invalid_o(invalid)
    );

    localparam logic [127:0] DST_PAT = 128'hA5A5_5A5A_F00D_CAFE_1234_5678_9ABC_DEF0;

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int ewidth(input logic [1:0] code);
        return 8 << (code ^ 2'b10);
    endfunction

    function automatic logic [63:0] enc(input real x, input logic [1:0] code);
        logic [63:0] b = $realtobits(x);
        int e = int'(b[62:52]) - 1023;
        if (code == 2'b01) return b;
        if (b[62:0] == '0) return (code == 2'b00) ? {32'b0, b[63], 31'b0} : {48'b0, b[63], 15'b0};
        if (code == 2'b00) return {32'b0, b[63], 8'(e + 127), b[51:29]};
        return {48'b0, b[63], 5'(e + 15), b[51:42]};
    endfunction

    function automatic real dec(input logic [63:0] v, input logic [1:0] code);
        logic s;
        int e;
        if (code == 2'b01) return $realtobits(0.0) == 0 ? $bitstoreal(v) : 0.0;
        if (code == 2'b00) begin
            s = v[31]; e = int'(v[30:23]);
            if (e == 0) return $bitstoreal({s, 63'b0});
            return $bitstoreal({s, 11'(e - 127 + 1023), v[22:0], 29'b0});
        end
        s = v[15]; e = int'(v[14:10]);
        if (e == 0) return $bitstoreal({s, 63'b0});
        return $bitstoreal({s, 11'(e - 15 + 1023), v[9:0], 42'b0});
    endfunction

    function automatic real ref_round(input real x, input logic [1:0] m);
        real fl = $floor(x);
        real r;
        case (m)
            2'b00: begin
                if (x - fl > 0.5) r = fl + 1.0;
                else if (x - fl < 0.5) r = fl;
                else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            2'b01: r = $ceil(x);
            2'b10: r = fl;
            default: r = (x < 0.0) ? $ceil(x) : fl;
        endcase
        if (r == 0.0) r = $bitstoreal({($realtobits(x) >> 63) != 0 ? 1'b1 : 1'b0, 63'b0});
        return r;
    endfunction

    function automatic logic [127:0] place(input logic [63:0] el, input logic [1:0] code, input logic mg);
        int w = ewidth(code);
        logic [127:0] keep = mg ? DST_PAT : '0;
        logic [127:0] mask = ({128{1'b1}} << w);
        return (keep & mask) | ({64'b0, el} & ~mask);
    endfunction

    task automatic apply(input logic [127:0] s, input logic [1:0] c, input logic [1:0] m, input logic mg);
        @(negedge clk);
        src = s; ftype = c; rmode = m; merge = mg; dst = DST_PAT;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R13 reset result", result, '0);
        chk("R13 reset flags", {126'b0, undef, invalid}, '0);
    endtask

    task automatic run_val(input string req, input real x, input logic [1:0] c, input logic [1:0] m, input logic mg);
        logic [63:0] b = enc(x, c);
        real xe = dec(b, c);
        logic [63:0] e = enc(ref_round(xe, m), c);
        apply({64'h0BAD_F00D_0BAD_F00D, b}, c, m, mg);
        chk(req, result, place(e, c, mg));
        chk("R10 no flag", {126'b0, undef, invalid}, '0);
    endtask

    task automatic t_ties;
        real v[7] = '{0.5, 1.5, 2.5, -0.5, -1.5, -2.5, 3.5};
        logic [1:0] codes[3] = '{2'b00, 2'b01, 2'b11};
        foreach (codes[c]) foreach (v[i]) run_val("R6 tie even", v[i], codes[c], 2'b00, 1'b0);
        run_val("R6 0.5 to +0", 0.5, 2'b00, 2'b00, 1'b0);
        checks++; if (result[31:0] !== 32'h0000_0000) begin fails++; $display("FAIL R6: got %h expected 00000000", result[31:0]); end
        run_val("R6 -0.5 to -0", -0.5, 2'b00, 2'b00, 1'b0);
        chk("R6 -0.5 to -0 bits", result, 128'h8000_0000);
    endtask

    task automatic t_modes;
        real v[10] = '{1.25, -1.75, 123.456, -1000.6, 2047.5, 7.5, -3.25, 42.0, 9.99, -0.9};
        logic [1:0] codes[3] = '{2'b00, 2'b01, 2'b11};
        foreach (codes[c]) for (int m = 0; m < 4; m++) foreach (v[i])
            run_val(m == 0 ? "R6 nearest" : "R7 directed", v[i], codes[c], 2'(m), m[0]);
        run_val("R1 single sized lane", 2.7, 2'b00, 2'b11, 1'b1);
        run_val("R1 half sized lane", 2.7, 2'b11, 2'b11, 1'b1);
        run_val("R1 double sized lane", 2.7, 2'b01, 2'b11, 1'b1);
    endtask

    task automatic t_small;
        for (int m = 0; m < 4; m++) begin
            run_val("R8 +0.3", 0.3, 2'b00, 2'(m), 1'b0);
            run_val("R8 -0.3", -0.3, 2'b00, 2'(m), 1'b0);
            run_val("R8 +0.75 half", 0.75, 2'b11, 2'(m), 1'b0);
        end
        run_val("R8 -0.3 up gives -0", -0.3, 2'b00, 2'b01, 1'b0);
        chk("R8 -0.3 up bits", result, 128'h8000_0000);
        apply(128'h1, 2'b00, 2'b01, 1'b0);
        chk("R8 subnormal up", result, 128'h3F80_0000);
        apply(128'h8000_0001, 2'b00, 2'b10, 1'b0);
        chk("R8 neg subnormal down", result, 128'hBF80_0000);
        apply(128'h8000_0001, 2'b00, 2'b00, 1'b0);
        chk("R8 neg subnormal near", result, 128'h8000_0000);
    endtask

    task automatic t_integral;
        apply({64'h0, 32'h0, 1'b0, 8'(127 + 23), 23'h12_3457}, 2'b00, 2'b01, 1'b0);
        chk("R9 single large", result, {96'h0, 1'b0, 8'(127 + 23), 23'h12_3457});
        apply({64'h0, 1'b1, 11'(1023 + 60), 52'hF_EDCB_A987_6543}, 2'b01, 2'b00, 1'b0);
        chk("R9 double large", result, {64'h0, 1'b1, 11'(1023 + 60), 52'hF_EDCB_A987_6543});
        apply({112'h0, 1'b0, 5'(15 + 10), 10'h3FF}, 2'b11, 2'b10, 1'b0);
        chk("R9 half large", result, {112'h0, 1'b0, 5'(15 + 10), 10'h3FF});
    endtask

    task automatic t_specials;
        apply(128'h8000_0000, 2'b00, 2'b01, 1'b0);        chk("R3 -0 single", result, 128'h8000_0000);
        apply(128'h0, 2'b01, 2'b10, 1'b0);                chk("R3 +0 double", result, 128'h0);
        apply(128'hFF80_0000, 2'b00, 2'b00, 1'b0);        chk("R3 -inf single", result, 128'hFF80_0000);
        apply(128'h7C00, 2'b11, 2'b11, 1'b0);             chk("R3 +inf half", result, 128'h7C00);
        apply(128'h7FC0_0123, 2'b00, 2'b01, 1'b0);        chk("R4 qnan", result, 128'h7FC0_0123);
        chk("R4 qnan no flag", {127'b0, invalid}, '0);
        apply(128'h7F80_0123, 2'b00, 2'b01, 1'b0);        chk("R5 snan single", result, 128'h7FC0_0123);
        chk("R5 snan flag", {127'b0, invalid}, 128'h1);
        apply(128'hFFF0_0000_0000_0005, 2'b01, 2'b00, 1'b0); chk("R5 snan double", result, 128'hFFF8_0000_0000_0005);
        chk("R5 snan double flag", {127'b0, invalid}, 128'h1);
        apply(128'h7C01, 2'b11, 2'b00, 1'b1);             chk("R5 snan half merged", result, {DST_PAT[127:16], 16'h7E01});
    endtask

    task automatic t_undef;
        apply(128'h7F80_0123, 2'b10, 2'b00, 1'b1);
        chk("R2 illegal result", result, '0);
        chk("R2 illegal flags", {126'b0, undef, invalid}, 128'h2);
    endtask

    task automatic t_merge;
        run_val("R11 merge single", -7.5, 2'b00, 2'b00, 1'b1);
        run_val("R12 zero single", -7.5, 2'b00, 2'b00, 1'b0);
        run_val("R11 merge double", 5.5, 2'b01, 2'b11, 1'b1);
        run_val("R12 zero half", 5.5, 2'b11, 2'b11, 1'b0);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ties();
        t_modes();
        t_small();
        t_integral();
        t_specials();
        t_undef();
        t_merge();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule